// File: doc/BRIEF.md
# Buffered Program Command Sequencer

This block is the bus-side controller for buffered word programming in a NOR-style flash model. It decodes single-cycle write strobes on a word-addressed bus. A valid sequence unlocks the command set, opens a buffer on one sector, takes a word count, collects that many data words inside one aligned page, and then waits for a confirm command at the same sector. After the confirm it streams the buffered words, in load order, to a simple array port. It then waits for the array's completion pulse before it returns to read mode.

A wrong sector, a load outside the page or a non-confirm write after the last load puts the block in a sticky abort state. In that state it reports busy and abort. It leaves the state only through a dedicated three-write abort-reset sequence. A status read returns polling bits that let software follow the operation: a data-polling bit, a toggle bit and an abort bit.

Top module: `wbuf_prog_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `abort_flag` and `arr_wr` are 0 and `bus_rdata` is all zeros.
- R2: A buffer opens on 0xAA written to word address 0x555, then 0x55 to 0x2AA, then 0x25 to any address. That address selects the sector, which is the address bits from SECT_LSB upward. A wrong write during the two unlock steps returns the block to read mode with no abort and no busy.
- R3: The write after the open carries the word count minus one, from 0 to 2^PAGE_BITS-1, and must target the opened sector. A larger value or another sector aborts.
- R4: Each data-load write must target the opened sector and the page of the first load. The page is the address bits from PAGE_BITS upward. Any other address aborts.
- R5: After the last load, 0x29 written to the opened sector starts programming. Any other data, or any other sector, aborts.
- R6: Programming presents the loaded words on `arr_wr`/`arr_addr`/`arr_wdata`, one per cycle, in load order. The first word appears in the cycle after the confirm write. Each word's address is the page base plus that load's low PAGE_BITS address bits. `busy` is high from the cycle after the confirm until the cycle after `arr_done`.
- R7: In the abort state, `abort_flag` and `busy` are high and every other write is ignored. The writes 0xAA at 0x555, 0x55 at 0x2AA and 0xF0 at 0x555 clear both outputs in the cycle after the 0xF0 write. A wrong write in that sequence restarts it.
- R8: `bus_rdata` is updated only in the cycle after a `bus_re` strobe. Bit 1 is the abort flag and the other low bits are zero. While busy, bit 7 is the complement of bit 7 of the last loaded word, and bit 6 inverts on every read. Otherwise bit 7 equals that data bit and bit 6 holds its value.
- R9: Bus writes made while programming or waiting for `arr_done` are ignored. They change neither the words sent nor the return to read mode, and they cause no abort.
- R10: An `arr_done` pulse outside the wait for completion has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W | Word address of the write |
| bus_wdata | input | DATA_W | Write data / command byte |
| bus_re | input | 1 | Status read strobe |
| bus_rdata | output | DATA_W | Status word, registered |
| arr_wr | output | 1 | Array word program request |
| arr_addr | output | ADDR_W | Array word address |
| arr_wdata | output | DATA_W | Array word data |
| arr_done | input | 1 | Array completion pulse |
| busy | output | 1 | Operation running or aborted |
| abort_flag | output | 1 | Sticky abort indication |

## Verification
The assertions assume that `arr_done` arrives only after the last word has been sent and that reset is held low for several clock edges at start-up. They also assume that the bus never drives a write and a read in the same cycle. The bench drives each strobe for exactly one cycle, with idle cycles between strobes. It produces the completion pulse only after it has logged every expected array word plus a fixed latency. It issues reads and writes only from separate task calls.

// File: rtl/wbps_pkg.sv
// Package: shared state type and command codes for the buffered program
// sequencer. Assumes an 8-bit command field in the low data bits.
package wbps_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_UNL1, ST_UNL2, ST_COUNT, ST_LOAD, ST_CONFIRM,
        ST_PROG, ST_WAIT, ST_ABORT, ST_AB_UNL1, ST_AB_UNL2
    } seq_state_t;

    localparam int KEY_A_ADDR  = 'h555;
    localparam int KEY_B_ADDR  = 'h2AA;
    localparam int KEY_A_DATA  = 'hAA;
    localparam int KEY_B_DATA  = 'h55;
    localparam int OP_OPEN     = 'h25;
    localparam int OP_CONFIRM  = 'h29;
    localparam int OP_ABRST    = 'hF0;
endpackage

// File: rtl/wbps_decode.sv
// Module: combinational classification of one bus write against the command
// codes and against the opened sector and page. Assumes SECT_LSB >= PAGE_BITS.
module wbps_decode #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int SECT_LSB  = 12,
    parameter int PAGE_BITS = 4,
    localparam int SECT_W   = ADDR_W - SECT_LSB,
    localparam int TAG_W    = ADDR_W - PAGE_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic [SECT_W-1:0] open_sector,
    input  logic [TAG_W-1:0]  page_tag,
    input  logic              page_set,
    output logic              is_key_a,
    output logic              is_key_b,
    output logic              is_open,
    output logic              is_confirm,
    output logic              is_abrst,
    output logic              sect_ok,
    output logic              page_ok
);
    import wbps_pkg::*;

    // Command and address matching for the current write.
    always_comb begin
        is_key_a   = (addr == ADDR_W'(KEY_A_ADDR)) && (data == DATA_W'(KEY_A_DATA));
        is_key_b   = (addr == ADDR_W'(KEY_B_ADDR)) && (data == DATA_W'(KEY_B_DATA));
        is_open    = (data == DATA_W'(OP_OPEN));
        is_confirm = (data == DATA_W'(OP_CONFIRM));
        is_abrst   = (addr == ADDR_W'(KEY_A_ADDR)) && (data == DATA_W'(OP_ABRST));
        sect_ok    = (addr[ADDR_W-1:SECT_LSB] == open_sector);
        page_ok    = !page_set || (addr[ADDR_W-1:PAGE_BITS] == page_tag);
    end
endmodule

// File: rtl/wbps_buffer.sv
// Module: write buffer holding one data word and one in-page offset per load
// slot. Slots are written by load index and read back by index during program.
module wbps_buffer #(
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 4,
    localparam int DEPTH    = 1 << PAGE_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PAGE_BITS-1:0] wr_idx,
    input  logic [PAGE_BITS-1:0] wr_off,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [PAGE_BITS-1:0] rd_idx,
    output logic [PAGE_BITS-1:0] rd_off,
    output logic [DATA_W-1:0]    rd_data
);
    logic [DEPTH-1:0][DATA_W-1:0]    dv;
    logic [DEPTH-1:0][PAGE_BITS-1:0] ov;

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        logic [DATA_W-1:0]    q_data;
        logic [PAGE_BITS-1:0] q_off;
        // Capture one load into this slot when its index is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_data <= '0;
                q_off  <= '0;
            end else if (wr_en && wr_idx == PAGE_BITS'(e)) begin
                q_data <= wr_data;
                q_off  <= wr_off;
            end
        end
        assign dv[e] = q_data;
        assign ov[e] = q_off;
    end

    assign rd_data = dv[rd_idx];
    assign rd_off  = ov[rd_idx];
endmodule

// File: rtl/wbps_status.sv
// Module: registered status word for polling reads. Assumes DATA_W >= 8;
// bit 7 polls data, bit 6 toggles while busy, bit 1 reports abort.
module wbps_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              busy,
    input  logic              abort,
    input  logic              ref_bit,
    output logic [DATA_W-1:0] rdata
);
    logic              tog;
    logic              tog_nx;
    logic [DATA_W-1:0] word;

    // Build the next status word from the current condition.
    always_comb begin
        tog_nx  = busy ? ~tog : tog;
        word    = '0;
        word[7] = busy ? ~ref_bit : ref_bit;
        word[6] = tog_nx;
        word[1] = abort;
    end

    // Update the toggle and the read word on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog   <= 1'b0;
            rdata <= '0;
        end else if (rd_en) begin
            tog   <= tog_nx;
            rdata <= word;
        end
    end
endmodule

// File: rtl/wbuf_prog_seq.sv
// Module: buffered program sequencer top. Decodes the unlock/open/count/load/
// confirm write sequence, streams buffered words to the array and holds a
// sticky abort until the abort-reset sequence. Assumes one-cycle strobes.
module wbuf_prog_seq #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int SECT_LSB  = 12,
    parameter int PAGE_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              arr_wr,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    input  logic              arr_done,
    output logic              busy,
    output logic              abort_flag
);
    import wbps_pkg::*;

    localparam int DEPTH  = 1 << PAGE_BITS;
    localparam int SECT_W = ADDR_W - SECT_LSB;
    localparam int TAG_W  = ADDR_W - PAGE_BITS;

    seq_state_t           state;
    logic [PAGE_BITS-1:0] idx;
    logic [PAGE_BITS-1:0] cnt;
    logic [SECT_W-1:0]    sector;
    logic [TAG_W-1:0]     page_tag;
    logic                 page_set;
    logic                 last_bit7;
    logic is_key_a, is_key_b, is_open, is_confirm, is_abrst, sect_ok, page_ok;
    logic                 load_ok;
    logic [PAGE_BITS-1:0] rd_off;

    wbps_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB),
                  .PAGE_BITS(PAGE_BITS)) u_dec (
        .addr(bus_addr), .data(bus_wdata), .open_sector(sector),
        .page_tag(page_tag), .page_set(page_set),
        .is_key_a(is_key_a), .is_key_b(is_key_b), .is_open(is_open),
        .is_confirm(is_confirm), .is_abrst(is_abrst),
        .sect_ok(sect_ok), .page_ok(page_ok)
    );

    // A load is accepted only inside the opened sector and page.
    assign load_ok = (state == ST_LOAD) && bus_we && sect_ok && page_ok;

    wbps_buffer #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(load_ok), .wr_idx(idx),
        .wr_off(bus_addr[PAGE_BITS-1:0]), .wr_data(bus_wdata),
        .rd_idx(idx), .rd_off(rd_off), .rd_data(arr_wdata)
    );

    // Sequence control: command decoding, loading, streaming and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            cnt       <= '0;
            sector    <= '0;
            page_tag  <= '0;
            page_set  <= 1'b0;
            last_bit7 <= 1'b0;
        end else begin
            case (state)
                ST_IDLE:    if (bus_we && is_key_a) state <= ST_UNL1;
                ST_UNL1:    if (bus_we) state <= is_key_b ? ST_UNL2 : ST_IDLE;
                ST_UNL2: if (bus_we) begin
                    if (is_open) begin
                        state    <= ST_COUNT;
                        sector   <= bus_addr[ADDR_W-1:SECT_LSB];
                        page_set <= 1'b0;
                        idx      <= '0;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_COUNT: if (bus_we) begin
                    if (sect_ok && bus_wdata < DATA_W'(DEPTH)) begin
                        cnt   <= bus_wdata[PAGE_BITS-1:0];
                        state <= ST_LOAD;
                    end else begin
                        state <= ST_ABORT;
                    end
                end
                ST_LOAD: if (bus_we) begin
                    if (load_ok) begin
                        page_tag  <= bus_addr[ADDR_W-1:PAGE_BITS];
                        page_set  <= 1'b1;
                        last_bit7 <= bus_wdata[7];
                        idx       <= idx + 1'b1;
                        if (idx == cnt) state <= ST_CONFIRM;
                    end else begin
                        state <= ST_ABORT;
                    end
                end
                ST_CONFIRM: if (bus_we) begin
                    idx   <= '0;
                    state <= (sect_ok && is_confirm) ? ST_PROG : ST_ABORT;
                end
                ST_PROG: begin
                    idx <= idx + 1'b1;
                    if (idx == cnt) state <= ST_WAIT;
                end
                ST_WAIT:    if (arr_done) state <= ST_IDLE;
                ST_ABORT:   if (bus_we && is_key_a) state <= ST_AB_UNL1;
                ST_AB_UNL1: if (bus_we) state <= is_key_b ? ST_AB_UNL2 : ST_ABORT;
                ST_AB_UNL2: if (bus_we) state <= is_abrst ? ST_IDLE : ST_ABORT;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the sequence state.
    always_comb begin
        abort_flag = (state == ST_ABORT) || (state == ST_AB_UNL1) || (state == ST_AB_UNL2);
        busy       = abort_flag || (state == ST_PROG) || (state == ST_WAIT);
        arr_wr     = (state == ST_PROG);
        arr_addr   = {page_tag, rd_off};
    end

    wbps_status #(.DATA_W(DATA_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .rd_en(bus_re), .busy(busy),
        .abort(abort_flag), .ref_bit(last_bit7), .rdata(bus_rdata)
    );
endmodule

// File: rtl/wbps_checker.sv
// Module: property checker for the buffered program sequencer, bound to the
// top. Assumes reset is held for several edges at start.
module wbps_checker #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              arr_wr,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              arr_done,
    input logic              busy,
    input logic              abort_flag
);
    import wbps_pkg::*;

    AST_ARR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr |-> busy); // R6
    AST_ARR_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr && $past(arr_wr)) |->
        (arr_addr[ADDR_W-1:PAGE_BITS] == $past(arr_addr[ADDR_W-1:PAGE_BITS]))); // R6
    AST_START_ON_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_wr) |-> $past(bus_we && bus_wdata == DATA_W'(OP_CONFIRM))); // R5
    AST_ABORT_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        abort_flag |-> busy); // R7
    AST_ABORT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(abort_flag) |-> $past(bus_we && bus_addr == ADDR_W'(KEY_A_ADDR)
                                    && bus_wdata == DATA_W'(OP_ABRST))); // R7
    AST_IDLE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(abort_flag)) |-> $past(arr_done)); // R6
    AST_STATUS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_re) |-> $stable(bus_rdata)); // R8
endmodule

bind wbuf_prog_seq wbps_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_done(arr_done),
    .busy(busy), .abort_flag(abort_flag)
);

// File: tb/sim_wbuf_prog_seq.sv
// Bench: directed scenarios, one task each, for the buffered program sequencer.
module sim_wbuf_prog_seq;
    localparam int CLK_P = 10;
    localparam int LAT   = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic        arr_wr;
    logic [15:0] arr_addr;
    logic [7:0]  arr_wdata;
    logic        arr_done = 1'b0;
    logic        busy;
    logic        abort_flag;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int log_n = 0;
    logic [15:0] log_a [64];
    logic [7:0]  log_d [64];

    wbuf_prog_seq u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_done(arr_done), .busy(busy), .abort_flag(abort_flag)
    );

    always #(CLK_P/2) clk = ~clk;

    // Log every array word away from the active edge.
    always @(negedge clk) begin
        if (arr_wr && log_n < 64) begin
            log_a[log_n] = arr_addr;
            log_d[log_n] = arr_wdata;
            log_n = log_n + 1;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog expired: actual %0d cycles expected < 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk);
        bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        v = bus_rdata;
    endtask

    task automatic open_buf(input logic [15:0] sa);
        wr(16'h555, 8'hAA); wr(16'h2AA, 8'h55); wr(sa, 8'h25);
    endtask

    task automatic abort_reset(input string req);
        wr(16'h555, 8'hAA); wr(16'h2AA, 8'h55); wr(16'h555, 8'hF0);
        chk(abort_flag == 1'b0, req, abort_flag, 0);
        chk(busy == 1'b0, req, busy, 0);
    endtask

    task automatic expect_abort(input string req);
        chk(abort_flag == 1'b1, req, abort_flag, 1);
        chk(busy == 1'b1, req, busy, 1);
    endtask

    // Full buffered program of n words into page pg, with optional stray writes.
    task automatic t_program(input logic [15:0] pg, input int n, input int seed, input bit stray);
        logic [15:0] ea [16];
        logic [7:0]  ed [16];
        logic [7:0]  s1, s2;
        log_n = 0;
        open_buf(pg);
        wr(pg, 8'(n - 1));
        for (int i = 0; i < n; i++) begin
            ea[i] = pg | 16'((i * 7 + seed) % 16);
            ed[i] = 8'(seed * 37 + i * 91 + 5);
            wr(ea[i], ed[i]);
        end
        chk(busy == 1'b0, "R4 busy low before confirm", busy, 0);
        wr(pg, 8'h29);
        chk(busy == 1'b1, "R6 busy after confirm", busy, 1);
        chk(arr_wr == 1'b1 && arr_addr == ea[0], "R6 first word next cycle", arr_addr, ea[0]);
        for (int k = 0; k < 40 && log_n < n; k++) @(negedge clk);
        if (stray) begin
            wr(16'h555, 8'hAA); wr(16'h2AA, 8'h55); wr(pg, 8'h25); wr(pg, 8'h29);
            chk(abort_flag == 1'b0, "R9 stray writes no abort", abort_flag, 0);
        end
        rd(s1); rd(s2);
        chk(s1[7] == ~ed[n-1][7], "R8 poll bit complement while busy", s1[7], ~ed[n-1][7]);
        chk(s1[6] != s2[6], "R8 toggle bit while busy", s2[6], ~s1[6]);
        chk(busy == 1'b1, "R6 busy held until done", busy, 1);
        repeat (LAT) @(negedge clk);
        arr_done = 1'b1;
        @(negedge clk);
        arr_done = 1'b0;
        chk(busy == 1'b0, "R6 busy clears after done", busy, 0);
        chk(log_n == n, "R6 word count", log_n, n);
        for (int i = 0; i < n; i++) begin
            chk(log_a[i] == ea[i], "R6 word address", log_a[i], ea[i]);
            chk(log_d[i] == ed[i], stray ? "R9 word data" : "R6 word data", log_d[i], ed[i]);
        end
        rd(s1); rd(s2);
        chk(s1[7] == ed[n-1][7], "R8 poll bit true in read mode", s1[7], ed[n-1][7]);
        chk(s1[6] == s2[6], "R8 toggle holds in read mode", s2[6], s1[6]);
        chk(s1[1] == 1'b0 && s1[5:2] == 4'b0 && s1[0] == 1'b0, "R8 other bits zero", s1, 0);
    endtask

    task automatic t_reset;
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(abort_flag == 1'b0, "R1 abort", abort_flag, 0);
        chk(arr_wr == 1'b0, "R1 arr_wr", arr_wr, 0);
        chk(bus_rdata == 8'h00, "R1 rdata", bus_rdata, 0);
    endtask

    task automatic t_bad_unlock;
        wr(16'h555, 8'hAA); wr(16'h2AB, 8'h55); wr(16'h1000, 8'h25);
        wr(16'h1000, 8'h00); wr(16'h1000, 8'h11); wr(16'h1000, 8'h29);
        chk(busy == 1'b0 && abort_flag == 1'b0, "R2 broken unlock ignored", busy, 0);
        chk(arr_wr == 1'b0, "R2 no program", arr_wr, 0);
        wr(16'h555, 8'hAA); wr(16'h2AA, 8'h55); wr(16'h1000, 8'h26);
        wr(16'h1000, 8'h00);
        chk(busy == 1'b0 && abort_flag == 1'b0, "R2 wrong open code ignored", busy, 0);
    endtask

    task automatic t_abort_cases;
        logic [7:0] s;
        open_buf(16'h2000); wr(16'h3000, 8'h01);
        expect_abort("R3 count wrong sector");
        abort_reset("R7 reset after count sector");
        open_buf(16'h2000); wr(16'h2000, 8'h10);
        expect_abort("R3 count too large");
        abort_reset("R7 reset after count size");
        open_buf(16'h2000); wr(16'h2000, 8'h00); wr(16'h5000, 8'h33);
        expect_abort("R4 load other sector");
        abort_reset("R7 reset after load sector");
        open_buf(16'h3000); wr(16'h3000, 8'h02); wr(16'h3010, 8'hC3); wr(16'h3025, 8'h44);
        expect_abort("R4 load other page");
        rd(s);
        chk(s[1] == 1'b1, "R8 abort bit in status", s[1], 1);
        chk(s[7] == 1'b0, "R8 poll bit complement in abort", s[7], 0);
        wr(16'h3000, 8'h29); wr(16'h555, 8'hF0);
        expect_abort("R7 stray writes keep abort");
        wr(16'h555, 8'hAA); wr(16'h2AA, 8'h55); wr(16'h555, 8'h00);
        expect_abort("R7 broken reset sequence");
        chk(arr_wr == 1'b0, "R7 no program in abort", arr_wr, 0);
        abort_reset("R7 reset after page");
        open_buf(16'h4000); wr(16'h4000, 8'h00); wr(16'h4003, 8'h12); wr(16'h4000, 8'h30);
        expect_abort("R5 wrong confirm data");
        abort_reset("R7 reset after confirm data");
        open_buf(16'h4000); wr(16'h4000, 8'h00); wr(16'h4003, 8'h12); wr(16'h6000, 8'h29);
        expect_abort("R5 confirm other sector");
        abort_reset("R7 reset after confirm sector");
    endtask

    task automatic t_stray_done;
        @(negedge clk);
        arr_done = 1'b1;
        @(negedge clk);
        arr_done = 1'b0;
        chk(busy == 1'b0 && arr_wr == 1'b0, "R10 done in idle ignored", busy, 0);
        open_buf(16'h7000); wr(16'h7000, 8'h01);
        @(negedge clk); arr_done = 1'b1; @(negedge clk); arr_done = 1'b0;
        wr(16'h7005, 8'h81); wr(16'h7006, 8'h02); wr(16'h7000, 8'h29);
        chk(busy == 1'b1, "R10 done during load ignored", busy, 1);
        for (int k = 0; k < 10; k++) @(negedge clk);
        arr_done = 1'b1; @(negedge clk); arr_done = 1'b0;
        chk(busy == 1'b0, "R10 sequence completes", busy, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program(16'h1230, 1, 3, 1'b0);
        t_program(16'h2040, 16, 9, 1'b0);
        t_program(16'hA5F0, 5, 14, 1'b1);
        t_bad_unlock();
        t_abort_cases();
        t_stray_done();
        t_program(16'h0010, 3, 1, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule